// File: doc/BRIEF.md
# Asynchronous Serial Interface Adapter

A byte-wide asynchronous serial adapter that sits behind a small register port. It has one holding register per direction and one shift register per direction. A single control byte sets three things: how many baud ticks make one bit time, the character format, and the transmit-side options. The transmit-side options drive the RTS pin, enable the transmit interrupt and can force a break onto the line. A status byte reports the holding-register flags, the error flags, the two modem inputs and the interrupt request.

The bit-rate clock comes from outside as a one-cycle `baud_tick` strobe in the system clock domain. The transmitter starts each bit on a tick. The receiver finds the falling edge of a start bit and, in the divided modes, samples every bit at its middle. `reg_sel` picks the register: 0 means control on a write and status on a read, and 1 means the data registers.

Top module: `sio_adapter`

## Requirements
- R1: Control code 3 in bits [1:0] is a master reset. It idles both shifters, clears receive-full and all error flags, and sets transmit-empty. This state is also the reset state (control = 0x03). `txd` idles high.
- R2: Control bits [1:0] set the ticks per bit: 0 gives 1, 1 gives 16 and 2 gives 64.
- R3: Control bits [4:2] set the format as data/parity/stop: 0=7E2, 1=7O2, 2=7E1, 3=7O1, 4=8N2, 5=8N1, 6=8E1, 7=8O1. A frame is sent as a low start bit, then the data bits LSB first, then the parity bit if the format has one, then the high stop bit(s).
- R4: Control bits [6:5] set transmit control. 0 gives `rts_n` low with the transmit interrupt off. 1 gives `rts_n` low with the transmit interrupt on. 2 gives `rts_n` high with the transmit interrupt off. 3 gives `rts_n` low with the transmit interrupt off and holds `txd` low (break).
- R5: Control bit 7 enables the receive interrupt, which is raised by receive-full or overrun.
- R6: The status bits are: 0 receive-full, 1 transmit-empty, 2 the `dcd_n` level, 3 the `cts_n` level, 4 framing error, 5 overrun, 6 parity error, 7 interrupt request. The modem inputs pass through two synchronising flops. Transmit-empty reads 0 while `cts_n` is high.
- R7: A write to the transmit data register clears transmit-empty. Transmit-empty is set again on the tick where the byte moves into the shifter.
- R8: A read of the receive data register clears receive-full, overrun, framing error and parity error.
- R9: If a character completes while receive-full is still set, overrun is set. The earlier character stays in the receive data register and the new one is dropped.
- R10: In the divided modes, the receiver accepts a start bit only if the line is still low at the mid-bit tick (tick 8 or 32 after the edge). After that it samples each bit a full bit time later. In divide-by-1 it samples on every tick after the edge.
- R11: A low first stop bit sets framing error. A parity mismatch sets parity error. For 7-bit formats, bit 7 of the received data reads 0.
- R12: `irq_n` is low exactly when (bit 7 and (receive-full or overrun)) or (transmit control = 1 and the visible transmit-empty is set).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle bit-rate strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on data reads) |
| reg_sel | input | 1 | 0: control/status, 1: data |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data: status or receive data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts_n | input | 1 | Clear-to-send, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| rts_n | output | 1 | Request-to-send, active low |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that the control register is not rewritten in the cycle after a master-reset write. They also assume that a data read which coincides with a completing character is excluded from the flag-clearing property, because the new character takes precedence there. The stimulus keeps every serial bit an exact multiple of the free-running tick period. It changes the divide factor or the format only while both shifters are idle, and it moves the modem inputs only between characters.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = 12;

    typedef struct packed {
        logic [3:0] ndata;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } fmt_t;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_e;

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] tdr;
        logic       tdre;
        logic [7:0] rdr;
        logic       rdrf;
        logic       fe;
        logic       ovrn;
        logic       pe;
        logic [2:0] meta;
        logic [2:0] sync;
    } sio_regs_t;

    function automatic fmt_t fmt_decode(input logic [2:0] f);
        fmt_t r;
        r.ndata    = f[2] ? 4'd8 : 4'd7;
        r.par_en   = !(f == 3'd4 || f == 3'd5);
        r.par_odd  = f[0];
        r.two_stop = (f == 3'd0 || f == 3'd1 || f == 3'd4);
        return r;
    endfunction
endpackage

// File: rtl/sio_tx.sv
module sio_tx import sio_pkg::*; #(
    parameter int DIV_A = 16,
    parameter int DIV_B = 64,
    parameter int CNT_W = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        srst,
    input  logic        tick,
    input  logic [1:0]  div_sel,
    input  logic [2:0]  fmt_sel,
    input  logic        load_valid,
    input  logic [7:0]  load_data,
    output logic        take,
    output logic        line
);
    localparam logic [CNT_W-1:0] LAST_A = CNT_W'(DIV_A - 1);
    localparam logic [CNT_W-1:0] LAST_B = CNT_W'(DIV_B - 1);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] shreg;
        logic [3:0]         left;
        logic [CNT_W-1:0]   cnt;
        logic               line;
    } tx_t;

    localparam tx_t TX_IDLE = '{busy: 1'b0, shreg: '1, left: '0, cnt: '0, line: 1'b1};

    tx_t                q, d;
    fmt_t               fm;
    logic [CNT_W-1:0]   last_cnt;
    logic [FRAME_W-1:0] fr_new;
    logic [3:0]         flen;
    logic               par;

    always_comb begin
        case (div_sel)
            2'd1:    last_cnt = LAST_A;
            2'd2:    last_cnt = LAST_B;
            default: last_cnt = '0;
        endcase
    end

    always_comb begin
        fm   = fmt_decode(fmt_sel);
        par  = ^(load_data & ((fm.ndata == 4'd8) ? 8'hFF : 8'h7F)) ^ fm.par_odd;
        fr_new    = '1;
        fr_new[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < int'(fm.ndata)) fr_new[i+1] = load_data[i];
        end
        if (fm.par_en) fr_new[fm.ndata + 4'd1] = par;
        flen = 4'd1 + fm.ndata + {3'd0, fm.par_en} + (fm.two_stop ? 4'd2 : 4'd1);
        take = tick & ~srst & ~q.busy & load_valid;

        d = q;
        if (srst) begin
            d = TX_IDLE;
        end else if (take) begin
            d.busy  = 1'b1;
            d.shreg = fr_new;
            d.line  = fr_new[0];
            d.left  = flen - 4'd1;
            d.cnt   = '0;
        end else if (q.busy && tick) begin
            if (q.cnt == last_cnt) begin
                d.cnt = '0;
                if (q.left == 4'd0) begin
                    d.busy = 1'b0;
                    d.line = 1'b1;
                end else begin
                    d.shreg = q.shreg >> 1;
                    d.line  = q.shreg[1];
                    d.left  = q.left - 4'd1;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= TX_IDLE;
        else        q <= d;
    end

    assign line = q.line;
endmodule

// File: rtl/sio_rx.sv
module sio_rx import sio_pkg::*; #(
    parameter int DIV_A = 16,
    parameter int DIV_B = 64,
    parameter int CNT_W = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        srst,
    input  logic        tick,
    input  logic [1:0]  div_sel,
    input  logic [2:0]  fmt_sel,
    input  logic        rxd,
    output logic        done,
    output logic [7:0]  data,
    output logic        fe,
    output logic        pe
);
    localparam logic [CNT_W-1:0] LAST_A = CNT_W'(DIV_A - 1);
    localparam logic [CNT_W-1:0] LAST_B = CNT_W'(DIV_B - 1);
    localparam logic [CNT_W-1:0] HALF_A = CNT_W'(DIV_A / 2);
    localparam logic [CNT_W-1:0] HALF_B = CNT_W'(DIV_B / 2);

    typedef struct packed {
        rx_st_e           st;
        logic [CNT_W-1:0] cnt;
        logic [3:0]       idx;
        logic [9:0]       bits;
        logic             done;
        logic [7:0]       data;
        logic             fe;
        logic             pe;
    } rx_t;

    localparam rx_t RX_RST = '{st: RX_IDLE, cnt: '0, idx: '0, bits: '0,
                               done: 1'b0, data: '0, fe: 1'b0, pe: 1'b0};

    rx_t              q, d;
    fmt_t             fm;
    logic [CNT_W-1:0] last_cnt, half_cnt;
    logic [3:0]       last_idx;
    logic [7:0]       rx_data;
    logic             par_bit;

    always_comb begin
        case (div_sel)
            2'd1:    begin last_cnt = LAST_A; half_cnt = HALF_A; end
            2'd2:    begin last_cnt = LAST_B; half_cnt = HALF_B; end
            default: begin last_cnt = '0;     half_cnt = '0;     end
        endcase
    end

    always_comb begin
        fm       = fmt_decode(fmt_sel);
        last_idx = fm.ndata + {3'd0, fm.par_en};
        rx_data  = '0;
        for (int i = 0; i < 8; i++) begin
            if (i < int'(fm.ndata)) rx_data[i] = q.bits[i];
        end
        par_bit = q.bits[fm.ndata];

        d      = q;
        d.done = 1'b0;
        if (srst) begin
            d.st  = RX_IDLE;
            d.cnt = '0;
            d.idx = '0;
        end else if (tick) begin
            case (q.st)
                RX_IDLE: if (!rxd) begin
                    d.idx = '0;
                    if (last_cnt == '0) begin
                        d.st  = RX_BITS;
                        d.cnt = '0;
                    end else begin
                        d.st  = RX_START;
                        d.cnt = CNT_W'(1);
                    end
                end
                RX_START: begin
                    if (q.cnt == half_cnt) begin
                        d.cnt = '0;
                        d.st  = rxd ? RX_IDLE : RX_BITS;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_BITS: begin
                    if (q.cnt == last_cnt) begin
                        d.cnt         = '0;
                        d.bits[q.idx] = rxd;
                        d.idx         = q.idx + 4'd1;
                        if (q.idx == last_idx) begin
                            d.st   = RX_IDLE;
                            d.done = 1'b1;
                            d.data = rx_data;
                            d.fe   = ~rxd;
                            d.pe   = fm.par_en & ((^rx_data ^ par_bit) != fm.par_odd);
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RX_RST;
        else        q <= d;
    end

    assign done = q.done;
    assign data = q.data;
    assign fe   = q.fe;
    assign pe   = q.pe;
endmodule

// File: rtl/sio_adapter.sv
module sio_adapter import sio_pkg::*; #(
    parameter int DIV_A = 16,
    parameter int DIV_B = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       reg_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       rxd,
    output logic       txd,
    input  logic       cts_n,
    input  logic       dcd_n,
    output logic       rts_n,
    output logic       irq_n
);
    localparam int CNT_W = $clog2(DIV_B) + 1;

    localparam sio_regs_t REGS_RST = '{ctrl: 8'h03, tdr: '0, tdre: 1'b1, rdr: '0,
                                       rdrf: 1'b0, fe: 1'b0, ovrn: 1'b0, pe: 1'b0,
                                       meta: 3'b001, sync: 3'b001};

    sio_regs_t  q, d;
    logic       srst, tx_take, tx_line, rx_done, rx_fe, rx_pe;
    logic       cts_s, dcd_s, tdre_vis, irq, rd_dat;
    logic [1:0] tx_ctl;
    logic [7:0] rx_data, status_w, ctrl_w, rdr_w;

    sio_tx #(.DIV_A(DIV_A), .DIV_B(DIV_B), .CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .srst(srst), .tick(baud_tick),
        .div_sel(q.ctrl[1:0]), .fmt_sel(q.ctrl[4:2]),
        .load_valid(~q.tdre), .load_data(q.tdr),
        .take(tx_take), .line(tx_line)
    );

    sio_rx #(.DIV_A(DIV_A), .DIV_B(DIV_B), .CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .srst(srst), .tick(baud_tick),
        .div_sel(q.ctrl[1:0]), .fmt_sel(q.ctrl[4:2]), .rxd(q.sync[0]),
        .done(rx_done), .data(rx_data), .fe(rx_fe), .pe(rx_pe)
    );

    always_comb begin
        srst     = (q.ctrl[1:0] == 2'b11);
        tx_ctl   = q.ctrl[6:5];
        cts_s    = q.sync[1];
        dcd_s    = q.sync[2];
        tdre_vis = q.tdre & ~cts_s;
        irq      = (q.ctrl[7] & (q.rdrf | q.ovrn)) | ((tx_ctl == 2'b01) & tdre_vis);
        status_w = {irq, q.pe, q.ovrn, q.fe, cts_s, dcd_s, tdre_vis, q.rdrf};
        rd_dat   = rd_en & reg_sel;

        d      = q;
        d.meta = {dcd_n, cts_n, rxd};
        d.sync = q.meta;
        if (wr_en && !reg_sel) d.ctrl = wr_data;
        if (srst) begin
            d.tdre = 1'b1;
            d.rdrf = 1'b0;
            d.fe   = 1'b0;
            d.ovrn = 1'b0;
            d.pe   = 1'b0;
        end else begin
            if (rd_dat) begin
                d.rdrf = 1'b0;
                d.fe   = 1'b0;
                d.ovrn = 1'b0;
                d.pe   = 1'b0;
            end
            if (tx_take) d.tdre = 1'b1;
            if (wr_en && reg_sel) begin
                d.tdr  = wr_data;
                d.tdre = 1'b0;
            end
            if (rx_done) begin
                if (q.rdrf && !rd_dat) begin
                    d.ovrn = 1'b1;
                end else begin
                    d.rdr  = rx_data;
                    d.rdrf = 1'b1;
                    d.fe   = rx_fe;
                    d.pe   = rx_pe;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    assign ctrl_w  = q.ctrl;
    assign rdr_w   = q.rdr;
    assign rd_data = reg_sel ? q.rdr : status_w;
    assign txd     = (tx_ctl == 2'b11) ? 1'b0 : tx_line;
    assign rts_n   = (tx_ctl == 2'b10);
    assign irq_n   = ~irq;
endmodule

// File: rtl/sio_adapter_chk.sv
module sio_adapter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       reg_sel,
    input logic [7:0] wr_data,
    input logic       txd,
    input logic       rts_n,
    input logic       irq_n,
    input logic [7:0] status,
    input logic [7:0] ctrl,
    input logic [7:0] rdr,
    input logic       rx_done
);
    AST_MRESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel && wr_data[1:0] == 2'b11) |=> ##1 (!status[0] && status[6:4] == 3'b000)); // R1

    AST_RTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel && wr_data[6:5] == 2'b10) |=> rts_n); // R4

    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel && wr_data[6:5] == 2'b11) |=> !txd); // R4

    AST_RX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[7] && status[0]) |-> !irq_n); // R5

    AST_TX_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel && ctrl[1:0] != 2'b11) |=> !status[1]); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel && !rx_done) |=> (!status[0] && status[6:4] == 3'b000)); // R8

    AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !(rd_en && reg_sel)) |=> $stable(rdr)); // R9
endmodule

bind sio_adapter sio_adapter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .txd(txd), .rts_n(rts_n), .irq_n(irq_n),
    .status(status_w), .ctrl(ctrl_w), .rdr(rdr_w), .rx_done(rx_done)
);

// File: tb/sim_sio_adapter.sv
module sim_sio_adapter;
    localparam int TP = 4;

    logic       clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, reg_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rxd = 1'b1, cts_n = 1'b0, dcd_n = 1'b0;
    logic [7:0] rd_data;
    logic       txd, rts_n, irq_n;
    int         checks = 0, errors = 0;

    always #2 clk = ~clk;

    sio_adapter u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en), .rd_en(rd_en),
        .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data), .rxd(rxd), .txd(txd),
        .cts_n(cts_n), .dcd_n(dcd_n), .rts_n(rts_n), .irq_n(irq_n)
    );

    initial begin
        forever begin
            repeat (TP - 1) @(posedge clk);
            baud_tick <= 1'b1;
            @(posedge clk);
            baud_tick <= 1'b0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] v);
        wr_en = 1'b1; reg_sel = sel; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        rd_en = 1'b1; reg_sel = sel;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic int bit_cyc(input logic [1:0] dv);
        return TP * ((dv == 2'd0) ? 1 : (dv == 2'd1) ? 16 : 64);
    endfunction

    task automatic exp_frame(input logic [2:0] f, input logic [7:0] v,
                             output logic [11:0] b, output int n, output int ppos);
        int  nd = f[2] ? 8 : 7;
        bit  pen = !(f == 3'd4 || f == 3'd5);
        int  ns = (f == 3'd0 || f == 3'd1 || f == 3'd4) ? 2 : 1;
        logic p = f[0];
        b = '1;
        b[0] = 1'b0;
        for (int i = 0; i < nd; i++) begin
            b[1+i] = v[i];
            p = p ^ v[i];
        end
        if (pen) b[1+nd] = p;
        ppos = 1 + nd;
        n = 1 + nd + (pen ? 1 : 0) + ns;
    endtask

    task automatic tx_frame(input logic [2:0] f, input logic [1:0] dv, input logic [7:0] v,
                            input string tag);
        logic [11:0] eb, cb;
        int n, pp, k;
        int bc = bit_cyc(dv);
        exp_frame(f, v, eb, n, pp);
        wr(1'b1, v);
        k = 0;
        while (txd !== 1'b0 && k < 20000) begin @(negedge clk); k++; end
        cb = '1;
        repeat (bc / 2) @(negedge clk);
        cb[0] = txd;
        for (int i = 1; i < n; i++) begin
            repeat (bc) @(negedge clk);
            cb[i] = txd;
        end
        check(tag, cb, eb);
        repeat (bc) @(negedge clk);
    endtask

    task automatic rx_frame(input logic [2:0] f, input logic [1:0] dv, input logic [7:0] v,
                            input bit bad_par, input bit bad_stop);
        logic [11:0] b;
        int n, pp;
        int bc = bit_cyc(dv);
        exp_frame(f, v, b, n, pp);
        if (bad_par) b[pp] = ~b[pp];
        if (bad_stop) b[n - ((f == 3'd0 || f == 3'd1 || f == 3'd4) ? 2 : 1)] = 1'b0;
        for (int i = 0; i < n; i++) begin
            rxd = b[i];
            repeat (bc) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] s;
        rd(1'b0, s);
        check("R1 reset status", s, 8'h02);
        check("R1 reset txd idle", txd, 1'b1);
        check("R4 reset rts_n", rts_n, 1'b0);
        check("R12 reset irq_n", irq_n, 1'b1);
    endtask

    task automatic t_tx_basic;
        logic [7:0] s;
        wr(1'b0, 8'h14);
        wr(1'b1, 8'hA5);
        rd(1'b0, s);
        check("R7 tdre cleared by write", s[1], 1'b0);
        wait_tx_done();
        rd(1'b0, s);
        check("R7 tdre set after move", s[1], 1'b1);
        tx_frame(3'd5, 2'd0, 8'h3C, "R2 R3 8N1 divide-by-1 frame");
    endtask

    task automatic wait_tx_done;
        repeat (12 * TP + 8) @(negedge clk);
    endtask

    task automatic t_formats;
        wr(1'b0, 8'h00);
        tx_frame(3'd0, 2'd0, 8'hB5, "R3 7E2 frame");
        wr(1'b0, 8'h0C);
        tx_frame(3'd3, 2'd0, 8'h35, "R3 7O1 frame");
        wr(1'b0, 8'h10);
        tx_frame(3'd4, 2'd0, 8'h81, "R3 8N2 frame");
        wr(1'b0, 8'h1C);
        tx_frame(3'd7, 2'd0, 8'hC3, "R3 8O1 frame");
        wr(1'b0, 8'h18);
        tx_frame(3'd6, 2'd0, 8'h07, "R3 8E1 frame");
    endtask

    task automatic t_rx_basic;
        logic [7:0] s, v;
        wr(1'b0, 8'h14);
        rx_frame(3'd5, 2'd0, 8'h5A, 1'b0, 1'b0);
        rd(1'b0, s);
        check("R6 status after rx", s, 8'h03);
        rd(1'b1, v);
        check("R3 rx 8N1 data", v, 8'h5A);
        rd(1'b0, s);
        check("R8 rdrf cleared by read", s, 8'h02);
        wr(1'b0, 8'h0C);
        rx_frame(3'd3, 2'd0, 8'hB5, 1'b0, 1'b0);
        rd(1'b1, v);
        check("R11 7-bit rx data bit7 zero", v, 8'h35);
        rd(1'b0, s);
        check("R11 good odd parity no error", s, 8'h02);
    endtask

    task automatic t_errors;
        logic [7:0] s, v;
        wr(1'b0, 8'h08);
        rx_frame(3'd2, 2'd0, 8'h35, 1'b1, 1'b0);
        rd(1'b0, s);
        check("R11 parity error flag", s, 8'h43);
        rd(1'b1, v);
        check("R11 data with parity error", v, 8'h35);
        rd(1'b0, s);
        check("R8 parity error cleared", s, 8'h02);
        wr(1'b0, 8'h14);
        rx_frame(3'd5, 2'd0, 8'h77, 1'b0, 1'b1);
        rd(1'b0, s);
        check("R11 framing error flag", s, 8'h13);
        rd(1'b1, v);
        rd(1'b0, s);
        check("R8 framing error cleared", s, 8'h02);
    endtask

    task automatic t_overrun;
        logic [7:0] s, v;
        rx_frame(3'd5, 2'd0, 8'h11, 1'b0, 1'b0);
        rx_frame(3'd5, 2'd0, 8'h22, 1'b0, 1'b0);
        rd(1'b0, s);
        check("R9 overrun flag", s, 8'h23);
        rd(1'b1, v);
        check("R9 earlier char kept", v, 8'h11);
        rd(1'b0, s);
        check("R8 overrun cleared", s, 8'h02);
    endtask

    task automatic t_div16;
        logic [7:0] s, v;
        wr(1'b0, 8'h15);
        rxd = 1'b0;
        repeat (6 * TP) @(negedge clk);
        rxd = 1'b1;
        repeat (20 * 16 * TP) @(negedge clk);
        rd(1'b0, s);
        check("R10 short start pulse rejected", s, 8'h02);
        rx_frame(3'd5, 2'd1, 8'hC6, 1'b0, 1'b0);
        rd(1'b1, v);
        check("R10 divide-by-16 rx data", v, 8'hC6);
        tx_frame(3'd5, 2'd1, 8'h96, "R2 divide-by-16 tx frame");
    endtask

    task automatic t_div64;
        logic [7:0] v;
        wr(1'b0, 8'h16);
        tx_frame(3'd5, 2'd2, 8'h81, "R2 divide-by-64 tx frame");
        rx_frame(3'd5, 2'd2, 8'h4B, 1'b0, 1'b0);
        rd(1'b1, v);
        check("R10 divide-by-64 rx data", v, 8'h4B);
    endtask

    task automatic t_txctrl;
        logic [7:0] s;
        wr(1'b0, 8'h54);
        check("R4 rts_n high", rts_n, 1'b1);
        wr(1'b0, 8'h74);
        check("R4 break holds txd low", txd, 1'b0);
        check("R4 break rts_n low", rts_n, 1'b0);
        wr(1'b0, 8'h34);
        check("R12 tx irq asserted", irq_n, 1'b0);
        rd(1'b0, s);
        check("R6 status with tx irq", s, 8'h82);
        cts_n = 1'b1;
        repeat (4) @(negedge clk);
        rd(1'b0, s);
        check("R6 cts high hides tdre", s, 8'h08);
        check("R12 irq drops with cts high", irq_n, 1'b1);
        dcd_n = 1'b1;
        repeat (4) @(negedge clk);
        rd(1'b0, s);
        check("R6 dcd bit", s, 8'h0C);
        cts_n = 1'b0;
        dcd_n = 1'b0;
        repeat (4) @(negedge clk);
        wr(1'b0, 8'h14);
        check("R12 tx irq off in mode 0", irq_n, 1'b1);
    endtask

    task automatic t_rx_irq;
        logic [7:0] s, v;
        wr(1'b0, 8'h94);
        check("R5 no irq while empty", irq_n, 1'b1);
        rx_frame(3'd5, 2'd0, 8'h3A, 1'b0, 1'b0);
        check("R5 rx irq asserted", irq_n, 1'b0);
        rd(1'b0, s);
        check("R5 status irq bit", s, 8'h83);
        rd(1'b1, v);
        check("R5 irq released by read", irq_n, 1'b1);
        wr(1'b0, 8'h14);
    endtask

    task automatic t_mreset;
        logic [7:0] s;
        rx_frame(3'd5, 2'd0, 8'h66, 1'b0, 1'b0);
        rx_frame(3'd5, 2'd0, 8'h67, 1'b0, 1'b0);
        wr(1'b0, 8'h03);
        @(negedge clk);
        rd(1'b0, s);
        check("R1 master reset clears flags", s, 8'h02);
        check("R1 master reset txd high", txd, 1'b1);
        wr(1'b0, 8'h14);
        tx_frame(3'd5, 2'd0, 8'h5E, "R1 tx works after master reset");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_basic();
        t_formats();
        t_rx_basic();
        t_errors();
        t_overrun();
        t_div16();
        t_div64();
        t_txctrl();
        t_rx_irq();
        t_mreset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule